// File: doc/BRIEF.md
# Soft-Start and Overcurrent Hiccup Sequencer

This block decides when the phase PWM outputs of a multi-phase buck regulator may switch, and produces the reference ramp used during start-up. It keeps the PWM drivers in their high-impedance state until the supply-good flag and the enable are both high. It then runs a soft-start whose length is a fixed count of switching-cycle ticks. During that soft-start the reference rises one step per tick. The soft-start ends when the output reports power-good or when the ramp reaches full scale.

The block compares the average of the current-sense codes of the active channels against a trip level. An overcurrent stops switching and waits for a delay as long as the soft-start interval, then retries. This repeats for as long as the fault persists. An overvoltage fault reported from outside is held internally. The held fault stops any new soft-start. Lowering and raising the enable does not clear it; only a loss of supply-good does.

Top module: `ss_hiccup_seq`

## Requirements
- R1: While `por_ok_i` is low, `pwm_en_o` is 0, `run_o` is 0 and `ss_ref_o` is 0 from the cycle after it is sampled low; the same holds while `en_i` is low.
- R2: With `por_ok_i` and `en_i` high and no held overvoltage, `pwm_en_o` rises one cycle after the block is idle with `ss_ref_o` = 0. Dropping `en_i` or `por_ok_i` in any state returns the block to idle on the next clock edge.
- R3: During soft-start, `ss_ref_o` rises by exactly one on each clock edge where `tick_i` is high, and holds its value when `tick_i` is low.
- R4: Soft-start ends on the edge where `pgood_i` is high, or on the tick that follows `ss_ref_o` = SS_CYCLES-1, whichever comes first. After it ends, `run_o` = 1, `pwm_en_o` = 1 and `ss_ref_o` = SS_CYCLES-1.
- R5: Overcurrent is present when 2 x (sum of the codes of channels 0 to `n_act_i`-1) > TRIP_X2 x `n_act_i`. Each code is CODE_W bits wide, and channel k sits at bits [k*CODE_W +: CODE_W] of `isen_i`. With the default TRIP_X2 = 165, an average of 82.5 code units is the trip level. Equality does not trip, and channels at or above `n_act_i` have no effect.
- R6: Overcurrent while in regulation sets `pwm_en_o` to 0 on the next edge, and every hiccup repeats with no retry limit. After exactly SS_CYCLES further ticks, a new soft-start begins with `ss_ref_o` = 0.
- R7: Overcurrent during soft-start sets `pwm_en_o` to 0 on the next edge. The soft-start tick count runs on to its end, then a full SS_CYCLES-tick delay follows, and then the retry.
- R8: A pulse on `ov_latched_i` is held. It does not stop an ongoing soft-start or regulation, but it prevents every new soft-start, including one after enable is toggled. Only `por_ok_i` low clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| por_ok_i | input | 1 | Supply above power-on threshold |
| en_i | input | 1 | Converter enable |
| tick_i | input | 1 | One pulse per switching cycle |
| isen_i | input | N_CH*CODE_W | Packed per-channel current codes |
| n_act_i | input | $clog2(N_CH+1) | Number of active channels, 1 to N_CH |
| pgood_i | input | 1 | Output within regulation window |
| ov_latched_i | input | 1 | Overvoltage fault report |
| pwm_en_o | output | 1 | 1 = PWM outputs drive, 0 = tri-state |
| ss_ref_o | output | $clog2(SS_CYCLES) | Soft-start reference ramp |
| run_o | output | 1 | Soft-start complete, regulating |

## Verification
A wrong state shows up as a wrong value on `pwm_en_o`, `run_o` or `ss_ref_o` within one clock edge of the input change that caused it. The slow faults can only be seen through timing. A tick counter that is reset too early or too late, or a soft-start cut short on overcurrent, shows only as `pwm_en_o` coming back at the wrong edge, thousands of cycles later. For that reason the bench samples the exact edges just before and just after each expected restart. A held overvoltage flag that clears when it should not shows only when the next start is attempted.

// File: rtl/ss_seq_pkg.sv
package ss_seq_pkg;
  typedef enum logic [2:0] {
    ST_OFF     = 3'd0,
    ST_SOFT    = 3'd1,
    ST_RUN     = 3'd2,
    ST_SS_WAIT = 3'd3,
    ST_DELAY   = 3'd4
  } ss_state_e;
endpackage

// File: rtl/ss_oc_detect.sv
module ss_oc_detect #(
  parameter int N_CH    = 4,
  parameter int CODE_W  = 8,
  parameter int CNT_W   = 3,
  parameter int TRIP_X2 = 165
) (
  input  logic [N_CH*CODE_W-1:0] codes_i,
  input  logic [CNT_W-1:0]       n_act_i,
  output logic                   trip_o
);
  localparam int SUM_W = CODE_W + $clog2(N_CH) + 1;

  logic [CODE_W-1:0] term [N_CH];
  logic [SUM_W-1:0]  sum;
  logic [31:0]       lhs, rhs;

  for (genvar g = 0; g < N_CH; g++) begin : g_mask
    assign term[g] = (CNT_W'(g) < n_act_i) ? codes_i[g*CODE_W +: CODE_W] : '0;
  end

  always_comb begin
    sum = '0;
    for (int g = 0; g < N_CH; g++) sum = sum + SUM_W'(term[g]);
  end

  // compare 2*sum against trip*n, no divider
  assign lhs    = 32'(sum) << 1;
  assign rhs    = 32'(TRIP_X2) * 32'(n_act_i);
  assign trip_o = lhs > rhs;
endmodule

// File: rtl/ss_tick_counter.sv
module ss_tick_counter #(
  parameter int SS_CYCLES = 2048,
  parameter int REF_W     = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             step_i,
  output logic [REF_W-1:0] cnt_o,
  output logic             last_o
);
  localparam logic [REF_W-1:0] CNT_MAX = REF_W'(SS_CYCLES - 1);

  assign last_o = step_i && (cnt_o == CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_o <= '0;
    else if (clr_i)   cnt_o <= '0;
    else if (last_o)  cnt_o <= '0;
    else if (step_i)  cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/ss_hiccup_seq.sv
module ss_hiccup_seq #(
  parameter int N_CH      = 4,
  parameter int CODE_W    = 8,
  parameter int SS_CYCLES = 2048,
  parameter int TRIP_X2   = 165,
  localparam int CNT_W    = $clog2(N_CH + 1),
  localparam int REF_W    = $clog2(SS_CYCLES)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   por_ok_i,
  input  logic                   en_i,
  input  logic                   tick_i,
  input  logic [N_CH*CODE_W-1:0] isen_i,
  input  logic [CNT_W-1:0]       n_act_i,
  input  logic                   pgood_i,
  input  logic                   ov_latched_i,
  output logic                   pwm_en_o,
  output logic [REF_W-1:0]       ss_ref_o,
  output logic                   run_o
);
  import ss_seq_pkg::*;

  localparam logic [REF_W-1:0] REF_FULL = REF_W'(SS_CYCLES - 1);

  ss_state_e        state_q, state_d;
  logic             ov_q, ov_hold, allow;
  logic             oc_hit, cnt_clr, cnt_step, ss_last;
  logic [REF_W-1:0] cnt;

  ss_oc_detect #(
    .N_CH(N_CH), .CODE_W(CODE_W), .CNT_W(CNT_W), .TRIP_X2(TRIP_X2)
  ) u_oc (
    .codes_i(isen_i),
    .n_act_i(n_act_i),
    .trip_o (oc_hit)
  );

  assign cnt_clr  = (state_q == ST_OFF) || (state_q == ST_RUN);
  assign cnt_step = tick_i && ((state_q == ST_SOFT) || (state_q == ST_SS_WAIT) ||
                               (state_q == ST_DELAY));

  ss_tick_counter #(.SS_CYCLES(SS_CYCLES), .REF_W(REF_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (cnt_clr),
    .step_i(cnt_step),
    .cnt_o (cnt),
    .last_o(ss_last)
  );

  // overvoltage hold: only supply loss clears it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           ov_q <= 1'b0;
    else if (!por_ok_i)    ov_q <= 1'b0;
    else if (ov_latched_i) ov_q <= 1'b1;
  end

  assign ov_hold = ov_q || ov_latched_i;
  assign allow   = por_ok_i && en_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_OFF:     if (!ov_hold) state_d = ST_SOFT;
      ST_SOFT: begin
        if (oc_hit)                  state_d = ss_last ? ST_DELAY : ST_SS_WAIT;
        else if (pgood_i || ss_last) state_d = ST_RUN;
      end
      ST_RUN:     if (oc_hit)  state_d = ST_DELAY;
      ST_SS_WAIT: if (ss_last) state_d = ST_DELAY;
      ST_DELAY:   if (ss_last) state_d = ov_hold ? ST_OFF : ST_SOFT;
      default:    state_d = ST_OFF;
    endcase
    if (!allow) state_d = ST_OFF;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_OFF;
    else         state_q <= state_d;
  end

  assign pwm_en_o = (state_q == ST_SOFT) || (state_q == ST_RUN);
  assign run_o    = (state_q == ST_RUN);
  assign ss_ref_o = (state_q == ST_SOFT) ? cnt :
                    (state_q == ST_RUN)  ? REF_FULL : '0;
endmodule

// File: rtl/ss_hiccup_seq_chk.sv
module ss_hiccup_seq_chk #(
  parameter int REF_W = 11
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             por_ok_i,
  input logic             en_i,
  input logic             ov_latched_i,
  input logic             oc_hit,
  input logic             pwm_en_o,
  input logic             run_o,
  input logic [REF_W-1:0] ss_ref_o
);
  logic ov_mdl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           ov_mdl <= 1'b0;
    else if (!por_ok_i)    ov_mdl <= 1'b0;
    else if (ov_latched_i) ov_mdl <= 1'b1;
  end

  // R1
  off_without_supply_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !por_ok_i |=> (!pwm_en_o && !run_o));

  // R2
  off_without_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!pwm_en_o && ss_ref_o == '0));

  // R3
  ramp_from_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwm_en_o) |-> ss_ref_o == '0);

  // R4
  run_after_soft_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_o) |-> $past(pwm_en_o));

  // R6
  trip_shutdown_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oc_hit && pwm_en_o && en_i && por_ok_i) |=> !pwm_en_o);

  // R8
  ov_blocks_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ov_mdl && !pwm_en_o && por_ok_i) |=> !pwm_en_o);
endmodule

bind ss_hiccup_seq ss_hiccup_seq_chk #(.REF_W(REF_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .por_ok_i    (por_ok_i),
  .en_i        (en_i),
  .ov_latched_i(ov_latched_i),
  .oc_hit      (oc_hit),
  .pwm_en_o    (pwm_en_o),
  .run_o       (run_o),
  .ss_ref_o    (ss_ref_o)
);

// File: tb/ss_hiccup_seq_tb_top.sv
`timescale 1ns/1ps
module ss_hiccup_seq_tb_top;
  localparam int N_CH      = 4;
  localparam int CODE_W    = 8;
  localparam int SS_CYCLES = 2048;
  localparam int CNT_W     = $clog2(N_CH + 1);
  localparam int REF_W     = $clog2(SS_CYCLES);
  localparam int FULL      = SS_CYCLES - 1;

  logic                   clk = 1'b0;
  logic                   rst_ni = 1'b0;
  logic                   por_ok = 1'b0, en = 1'b0, tick = 1'b1;
  logic                   pgood = 1'b0, ov = 1'b0;
  logic [N_CH*CODE_W-1:0] isen = '0;
  logic [CNT_W-1:0]       n_act = CNT_W'(4);
  logic                   pwm_en, run;
  logic [REF_W-1:0]       ss_ref;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  string            tag_q[$];
  logic [REF_W+1:0] exp_q[$];

  always #4 clk = ~clk;

  ss_hiccup_seq #(.N_CH(N_CH), .CODE_W(CODE_W), .SS_CYCLES(SS_CYCLES)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .por_ok_i(por_ok), .en_i(en), .tick_i(tick),
    .isen_i(isen), .n_act_i(n_act), .pgood_i(pgood), .ov_latched_i(ov),
    .pwm_en_o(pwm_en), .ss_ref_o(ss_ref), .run_o(run)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_o(input string tag, input bit p, input bit r, input int v);
    tag_q.push_back(tag);
    exp_q.push_back({p, r, REF_W'(v)});
  endtask

  task automatic set_codes(input int c0, input int c1, input int c2, input int c3);
    isen = {CODE_W'(c3), CODE_W'(c2), CODE_W'(c1), CODE_W'(c0)};
  endtask

  // monitor: compare queued expectations away from the active edge
  always @(negedge clk) begin
    #1;
    while (tag_q.size() > 0) begin
      string            t;
      logic [REF_W+1:0] e, a;
      t = tag_q.pop_front();
      e = exp_q.pop_front();
      a = {pwm_en, run, ss_ref};
      n_cmp++;
      if (a !== e) begin
        n_bad++;
        $display("FAIL %s: pwm/run/ref actual %0b/%0b/%0d expected %0b/%0b/%0d",
                 t, a[REF_W+1], a[REF_W], a[REF_W-1:0], e[REF_W+1], e[REF_W], e[REF_W-1:0]);
      end
    end
  end

  initial begin
    step(3);
    rst_ni = 1'b1;
    step(1); expect_o("R1 reset idle", 0, 0, 0);
    por_ok = 1'b1;
    step(5); expect_o("R1 enable low", 0, 0, 0);
    en = 1'b1;
    step(1); expect_o("R2 start", 1, 0, 0);
    step(10); expect_o("R3 ramp", 1, 0, 10);
    tick = 1'b0;
    step(5); expect_o("R3 no tick hold", 1, 0, 10);
    tick = 1'b1;
    step(2037); expect_o("R4 ramp top", 1, 0, FULL);
    step(1); expect_o("R4 end by ramp", 1, 1, FULL);
    n_act = CNT_W'(4); set_codes(82, 83, 83, 82);
    step(2); expect_o("R5 equal no trip", 1, 1, FULL);
    set_codes(83, 83, 83, 82);
    step(1); expect_o("R6 trip in run", 0, 0, 0);
    set_codes(0, 0, 0, 0);
    step(2047); expect_o("R6 delay not over", 0, 0, 0);
    step(1); expect_o("R6 retry", 1, 0, 0);
    step(99); expect_o("R3 ramp after retry", 1, 0, 99);
    n_act = CNT_W'(2); set_codes(0, 0, 255, 255);
    step(2); expect_o("R5 inactive ignored", 1, 0, 101);
    set_codes(83, 83, 0, 0);
    step(1); expect_o("R7 trip in soft", 0, 0, 0);
    set_codes(0, 0, 0, 0);
    step(3993); expect_o("R7 remainder plus delay", 0, 0, 0);
    step(1); expect_o("R7 retry", 1, 0, 0);
    step(20); expect_o("R3 ramp", 1, 0, 20);
    pgood = 1'b1;
    step(1); expect_o("R4 end by pgood", 1, 1, FULL);
    n_act = CNT_W'(3); set_codes(82, 82, 83, 255);
    step(2); expect_o("R5 three ch below", 1, 1, FULL);
    set_codes(82, 83, 83, 255);
    step(1); expect_o("R5 three ch trip", 0, 0, 0);
    set_codes(0, 0, 0, 0); pgood = 1'b0;
    en = 1'b0;
    step(1); expect_o("R2 enable drop", 0, 0, 0);
    en = 1'b1;
    step(1); expect_o("R2 restart", 1, 0, 0);
    ov = 1'b1;
    step(1); ov = 1'b0;
    step(2); expect_o("R8 running kept", 1, 0, 3);
    en = 1'b0;
    step(2); en = 1'b1;
    step(3); expect_o("R8 enable no clear", 0, 0, 0);
    por_ok = 1'b0;
    step(1); expect_o("R1 supply low", 0, 0, 0);
    por_ok = 1'b1;
    step(1); expect_o("R8 por clears", 1, 0, 0);
    step(2);
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung, expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule